// File: doc/BRIEF.md
# Automatic Transmit/Receive Pin Switcher

This block drives several banks of general-purpose output pins on an add-on board. Each pin either follows a software-written output value or is handed to an automatic transmit/receive selector. The selector picks one of two programmed pin patterns. Which pattern it picks depends on whether the transmit FIFO currently holds samples. The FIFO and the host bus are outside the block. The block sees a one-bit "FIFO holds data" flag and a simple register write port.

A single transmit/receive state is shared by all banks. Two global delay registers, counted in clock ticks, set how long the FIFO must stay non-empty before the banks move to the transmit pattern, and how long it must stay empty before they move back. A change of FIFO state that reverses before its delay has run out cancels the pending switch. The next change starts counting from zero. Per bank, a mask chooses bit by bit between the automatic pattern and the normal output register.

Top module: `trx_pin_switcher`

## Requirements
- R1: After reset every register holds 0, the switcher is in the receive state (`tx_active` = 0) and every pin output is 0.
- R2: Write addresses (with NB banks, default 4): bank b's mask at 3*b, its transmit pattern at 3*b+1, its receive pattern at 3*b+2; bank b's normal output register at 3*NB+b; transmit delay at 4*NB; receive delay at 4*NB+1. A write to any other address changes no pin.
- R3: A pin bit whose mask bit is 0 equals the matching bit of that bank's normal output register.
- R4: A pin bit whose mask bit is 1 equals the matching bit of the bank's transmit pattern while `tx_active` is 1, and of its receive pattern while it is 0.
- R5: In the receive state, once the FIFO flag has been sampled high at D+1 consecutive rising edges (D = transmit delay), `tx_active` is 1 after the last of those edges. It never rises without the flag sampled high at that edge.
- R6: In the transmit state, once the flag has been sampled low at D+1 consecutive edges (D = receive delay), `tx_active` is 0 after the last of those edges.
- R7: A run of the pending flag value that is broken before it completes cancels the pending switch. The state holds, and the next run counts from zero.
- R8: A delay of 0 makes the switch happen at the first edge that samples the new FIFO state.
- R9: A register write sampled at a rising edge shows on the pins after that edge and not before it.
- R10: The two delays and the state are shared: all banks change pattern at the same edge.
- R11: The delay is compared each cycle with its current register value. If a delay is lowered below the count already reached, the switch happens at the next edge that still samples the pending flag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW (5) | Register write address, per R2 |
| cfg_wdata | input | PW (16) | Register write data; delays take the low DW bits |
| fifo_busy | input | 1 | 1 while the transmit FIFO holds data |
| tx_active | output | 1 | 1 in the transmit state |
| pins_o | output | NB*PW (64) | Pin outputs, bank b on bits [b*PW +: PW] |

## Verification
The bench measures the switch edge exactly for a zero delay and a non-zero delay. A design that is off by one shows up as a state change one cycle early or late. It breaks a pending run one cycle before completion, which a counter that is not cleared on cancellation would turn into an early switch. It lowers a delay below the count already reached; an equality compare would then never switch. It also checks that a pin register write does not show before its edge, that a write to an unused address leaves every pin alone, and that all banks flip together. Long random runs mix flag bursts, register writes at random addresses and small random delays, and compare every cycle against a model computed from the requirements.

// File: rtl/trx_pkg.sv
package trx_pkg;

  // Shared transmit/receive state encoding.
  typedef enum logic {
    ST_RX = 1'b0,
    ST_TX = 1'b1
  } trx_state_e;

  // Address helpers for the write map; the stride of three per bank is fixed.
  function automatic int mask_addr(input int bank);
    return 3 * bank;
  endfunction

  function automatic int txval_addr(input int bank);
    return 3 * bank + 1;
  endfunction

  function automatic int rxval_addr(input int bank);
    return 3 * bank + 2;
  endfunction

  function automatic int io_addr(input int nbanks, input int bank);
    return 3 * nbanks + bank;
  endfunction

  function automatic int txdly_addr(input int nbanks);
    return 4 * nbanks;
  endfunction

  function automatic int rxdly_addr(input int nbanks);
    return 4 * nbanks + 1;
  endfunction

endpackage

// File: rtl/trx_rst_sync.sv
module trx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/trx_regfile.sv
module trx_regfile
  import trx_pkg::*;
#(
  parameter int NB = 4,
  parameter int PW = 16,
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [PW-1:0]    cfg_wdata,
  output logic [NB*PW-1:0] mask_flat,
  output logic [NB*PW-1:0] txv_flat,
  output logic [NB*PW-1:0] rxv_flat,
  output logic [NB*PW-1:0] io_flat,
  output logic [DW-1:0]    tx_dly,
  output logic [DW-1:0]    rx_dly
);

  localparam logic [AW-1:0] A_TXDLY = AW'(txdly_addr(NB));
  localparam logic [AW-1:0] A_RXDLY = AW'(rxdly_addr(NB));

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [AW-1:0] A_MASK = AW'(mask_addr(b));
    localparam logic [AW-1:0] A_TXV  = AW'(txval_addr(b));
    localparam logic [AW-1:0] A_RXV  = AW'(rxval_addr(b));
    localparam logic [AW-1:0] A_IO   = AW'(io_addr(NB, b));

    logic [PW-1:0] mask_q, txv_q, rxv_q, io_q;
    logic          mask_en, txv_en, rxv_en, io_en;

    always_comb begin
      mask_en = cfg_we && (cfg_addr == A_MASK);
      txv_en  = cfg_we && (cfg_addr == A_TXV);
      rxv_en  = cfg_we && (cfg_addr == A_RXV);
      io_en   = cfg_we && (cfg_addr == A_IO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q <= '0;
        txv_q  <= '0;
        rxv_q  <= '0;
        io_q   <= '0;
      end else begin
        if (mask_en) mask_q <= cfg_wdata;
        if (txv_en)  txv_q  <= cfg_wdata;
        if (rxv_en)  rxv_q  <= cfg_wdata;
        if (io_en)   io_q   <= cfg_wdata;
      end
    end

    assign mask_flat[b*PW +: PW] = mask_q;
    assign txv_flat[b*PW +: PW]  = txv_q;
    assign rxv_flat[b*PW +: PW]  = rxv_q;
    assign io_flat[b*PW +: PW]   = io_q;
  end

  // Delay registers take the low DW bits of the write data (DW <= PW).
  logic tx_dly_en, rx_dly_en;

  always_comb begin
    tx_dly_en = cfg_we && (cfg_addr == A_TXDLY);
    rx_dly_en = cfg_we && (cfg_addr == A_RXDLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_dly <= '0;
      rx_dly <= '0;
    end else begin
      if (tx_dly_en) tx_dly <= cfg_wdata[DW-1:0];
      if (rx_dly_en) rx_dly <= cfg_wdata[DW-1:0];
    end
  end

endmodule

// File: rtl/trx_delay_fsm.sv
module trx_delay_fsm
  import trx_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_busy,
  input  logic [DW-1:0] tx_dly,
  input  logic [DW-1:0] rx_dly,
  output logic          tx_active
);

  trx_state_e    st_q, st_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          st_en, cnt_en;
  logic          pending;
  logic [DW-1:0] limit;

  // The pending condition is the FIFO flag that opposes the current state.
  always_comb begin
    pending = (st_q == ST_RX) ? fifo_busy : !fifo_busy;
    limit   = (st_q == ST_RX) ? tx_dly : rx_dly;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (pending) begin
      if (cnt_q >= limit) begin
        st_d  = (st_q == ST_RX) ? ST_TX : ST_RX;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
    st_en  = (st_d != st_q);
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RX;
      cnt_q <= '0;
    end else begin
      if (st_en)  st_q  <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign tx_active = (st_q == ST_TX);

endmodule

// File: rtl/trx_bank_mux.sv
module trx_bank_mux #(
  parameter int PW = 16
) (
  input  logic          tx_active,
  input  logic [PW-1:0] mask,
  input  logic [PW-1:0] txv,
  input  logic [PW-1:0] rxv,
  input  logic [PW-1:0] io,
  output logic [PW-1:0] pins
);

  logic [PW-1:0] auto_val;

  always_comb begin
    auto_val = tx_active ? txv : rxv;
    for (int i = 0; i < PW; i++) begin
      pins[i] = mask[i] ? auto_val[i] : io[i];
    end
  end

endmodule

// File: rtl/trx_pin_switcher.sv
module trx_pin_switcher #(
  parameter int NB = 4,
  parameter int PW = 16,
  parameter int DW = 16,
  localparam int AW = $clog2(4 * NB + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [PW-1:0]    cfg_wdata,
  input  logic             fifo_busy,
  output logic             tx_active,
  output logic [NB*PW-1:0] pins_o
);

  logic             rst_sync_n;
  logic [NB*PW-1:0] mask_flat, txv_flat, rxv_flat, io_flat;
  logic [DW-1:0]    tx_dly, rx_dly;

  trx_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  trx_regfile #(.NB(NB), .PW(PW), .DW(DW), .AW(AW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .mask_flat (mask_flat),
    .txv_flat  (txv_flat),
    .rxv_flat  (rxv_flat),
    .io_flat   (io_flat),
    .tx_dly    (tx_dly),
    .rx_dly    (rx_dly)
  );

  trx_delay_fsm #(.DW(DW)) fsm_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fifo_busy (fifo_busy),
    .tx_dly    (tx_dly),
    .rx_dly    (rx_dly),
    .tx_active (tx_active)
  );

  for (genvar b = 0; b < NB; b++) begin : g_mux
    trx_bank_mux #(.PW(PW)) mux_i (
      .tx_active (tx_active),
      .mask      (mask_flat[b*PW +: PW]),
      .txv       (txv_flat[b*PW +: PW]),
      .rxv       (rxv_flat[b*PW +: PW]),
      .io        (io_flat[b*PW +: PW]),
      .pins      (pins_o[b*PW +: PW])
    );
  end

endmodule

// File: rtl/trx_switch_checker.sv
module trx_switch_checker #(
  parameter int NB = 4,
  parameter int PW = 16,
  parameter int DW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_busy,
  input logic             tx_active,
  input logic [NB*PW-1:0] mask_flat,
  input logic [NB*PW-1:0] txv_flat,
  input logic [NB*PW-1:0] rxv_flat,
  input logic [NB*PW-1:0] io_flat,
  input logic [NB*PW-1:0] pins_o,
  input logic [DW-1:0]    tx_dly,
  input logic [DW-1:0]    rx_dly
);

  assert_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pins_o ^ io_flat) & ~mask_flat) == '0);

  assert_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pins_o ^ (tx_active ? txv_flat : rxv_flat)) & mask_flat) == '0);

  assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !fifo_busy) |=> !tx_active);

  assert_rise_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> $past(fifo_busy));

  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && fifo_busy) |=> tx_active);

  assert_zero_tx_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && fifo_busy && tx_dly == '0) |=> tx_active);

  assert_zero_rx_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !fifo_busy && rx_dly == '0) |=> !tx_active);

endmodule

bind trx_pin_switcher trx_switch_checker #(.NB(NB), .PW(PW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .fifo_busy (fifo_busy),
  .tx_active (tx_active),
  .mask_flat (mask_flat),
  .txv_flat  (txv_flat),
  .rxv_flat  (rxv_flat),
  .io_flat   (io_flat),
  .pins_o    (pins_o),
  .tx_dly    (tx_dly),
  .rx_dly    (rx_dly)
);

// File: tb/trx_pin_switcher_tb_top.sv
module trx_pin_switcher_tb_top;

  localparam int CLK_P = 10;
  localparam int NB = 4;
  localparam int PW = 16;
  localparam int DW = 16;
  localparam int AW = $clog2(4 * NB + 2);

  logic             clk;
  logic             rst_n;
  logic             cfg_we;
  logic [AW-1:0]    cfg_addr;
  logic [PW-1:0]    cfg_wdata;
  logic             fifo_busy;
  logic             tx_active;
  logic [NB*PW-1:0] pins_o;

  int checks;
  int fails;

  trx_pin_switcher #(.NB(NB), .PW(PW), .DW(DW)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .fifo_busy (fifo_busy),
    .tx_active (tx_active),
    .pins_o    (pins_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // Reference model built from the requirements.
  logic [PW-1:0] m_mask [NB];
  logic [PW-1:0] m_txv  [NB];
  logic [PW-1:0] m_rxv  [NB];
  logic [PW-1:0] m_io   [NB];
  int            m_txd, m_rxd, m_cnt;
  logic          m_tx;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        m_mask[b] = '0; m_txv[b] = '0; m_rxv[b] = '0; m_io[b] = '0;
      end
      m_txd = 0; m_rxd = 0; m_cnt = 0; m_tx = 1'b0;
    end else begin
      // state step uses delay values held before this edge
      if ((m_tx ? !fifo_busy : fifo_busy)) begin
        if (m_cnt >= (m_tx ? m_rxd : m_txd)) begin
          m_tx = !m_tx;
          m_cnt = 0;
        end else begin
          m_cnt = m_cnt + 1;
        end
      end else begin
        m_cnt = 0;
      end
      if (cfg_we) begin
        for (int b = 0; b < NB; b++) begin
          if (int'(cfg_addr) == 3*b)      m_mask[b] = cfg_wdata;
          if (int'(cfg_addr) == 3*b + 1)  m_txv[b]  = cfg_wdata;
          if (int'(cfg_addr) == 3*b + 2)  m_rxv[b]  = cfg_wdata;
          if (int'(cfg_addr) == 3*NB + b) m_io[b]   = cfg_wdata;
        end
        if (int'(cfg_addr) == 4*NB)     m_txd = int'(cfg_wdata);
        if (int'(cfg_addr) == 4*NB + 1) m_rxd = int'(cfg_wdata);
      end
    end
  end

  function automatic logic [NB*PW-1:0] exp_pins();
    logic [NB*PW-1:0] r;
    for (int b = 0; b < NB; b++) begin
      r[b*PW +: PW] = (m_mask[b] & (m_tx ? m_txv[b] : m_rxv[b])) | (~m_mask[b] & m_io[b]);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [NB*PW-1:0] act, input logic [NB*PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write(input int a, input logic [PW-1:0] d);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [NB*PW-1:0] snap;

  initial begin
    void'($urandom(32'd20240611));
    checks = 0; fails = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; fifo_busy = 1'b0;
    steps(3);
    rst_n = 1'b1;
    steps(4);

    // R1 reset state
    check("R1 pins", pins_o, '0);
    check("R1 tx_active", {63'd0, tx_active}, '0);

    // R9 write visible only after its edge
    cfg_we = 1'b1; cfg_addr = AW'(3*NB + 0); cfg_wdata = 16'hA5A5;
    #1;
    check("R9 before edge", pins_o, '0);
    step();
    cfg_we = 1'b0;
    check("R9 after edge", {48'd0, pins_o[15:0]}, {48'd0, 16'hA5A5});

    // R3/R4 mask mixing, receive pattern
    write(0, 16'h00FF);
    write(1, 16'hBEEF);
    write(2, 16'h1234);
    check("R3 R4 rx mix", {48'd0, pins_o[15:0]}, {48'd0, 16'hA534});

    // R8 zero transmit delay: switch at first sampling edge
    fifo_busy = 1'b1;
    step();
    check("R8 tx after one edge", {63'd0, tx_active}, 64'd1);
    check("R4 tx mix", {48'd0, pins_o[15:0]}, {48'd0, 16'hA5EF});

    // R6 receive delay 3: four low samples needed
    write(4*NB + 1, 16'd3);
    fifo_busy = 1'b0;
    steps(3);
    check("R6 still tx after 3", {63'd0, tx_active}, 64'd1);
    step();
    check("R6 rx after 4", {63'd0, tx_active}, 64'd0);

    // R7 cancelled run
    write(4*NB, 16'd4);
    fifo_busy = 1'b1; steps(4);
    fifo_busy = 1'b0; step();
    check("R7 no switch after break", {63'd0, tx_active}, 64'd0);
    fifo_busy = 1'b1; steps(4);
    check("R7 restart count 4", {63'd0, tx_active}, 64'd0);
    step();
    check("R7 switch after 5", {63'd0, tx_active}, 64'd1);

    // R11 lowering the delay below the count reached
    write(4*NB + 1, 16'd10);
    fifo_busy = 1'b0; steps(4);
    write(4*NB + 1, 16'd2);
    check("R11 old delay still used", {63'd0, tx_active}, 64'd1);
    step();
    check("R11 switch next edge", {63'd0, tx_active}, 64'd0);

    // R10 banks switch together
    write(9, 16'hFFFF);
    write(10, 16'h0F0F);
    write(11, 16'hF0F0);
    check("R10 bank3 rx", {48'd0, pins_o[63:48]}, {48'd0, 16'hF0F0});
    fifo_busy = 1'b1; steps(5);
    check("R10 bank3 tx", {48'd0, pins_o[63:48]}, {48'd0, 16'h0F0F});
    check("R10 bank0 tx", {48'd0, pins_o[15:0]}, {48'd0, 16'hA5EF});

    // R2 unused address ignored
    snap = pins_o;
    write(25, 16'hFFFF);
    write(31, 16'h5555);
    check("R2 unused addr", pins_o, snap);
    check("R2 model agree", pins_o, exp_pins());

    // Random phase checked against the model
    for (int i = 0; i < 4000; i++) begin
      check("R2 R3 R4 R5 R6 random pins", pins_o, exp_pins());
      check("R5 R6 R7 random state", {63'd0, tx_active}, {63'd0, m_tx});
      if ($urandom % 6 == 0) fifo_busy = !fifo_busy;
      cfg_we = ($urandom % 4 == 0);
      cfg_addr = AW'($urandom % 32);
      cfg_wdata = (int'(cfg_addr) >= 4*NB) ? PW'($urandom % 9) : PW'($urandom);
      step();
    end
    cfg_we = 1'b0;
    finish_run();
  end

endmodule